// File: doc/BRIEF.md
# Debug Port Instruction Register with Command Decode

This block holds the instruction register of a boundary-scan debug port. A TAP controller outside the block supplies one-cycle strobes for its capture, shift, update and test-logic-reset states. While the shift strobe is high, the block moves serial data in from `tdi` at the top of a 16-bit shift stage and presents the bottom bit on `tdo`. When the update strobe arrives, the upper eight shift bits become the command byte of a 16-bit parallel register. The processor can only read this register. Its lower byte always reads as ones.

At the same update edge, a decoder turns the command byte into registered outputs. Three of them are selects for the external test, sample/preload and bypass paths. The fourth is a sticky debug-reset level, which commands whose top nibble is 0111 raise and commands whose top nibble is 0110 lower. The fifth is a one-cycle debug interrupt request for commands whose top three bits are 101. Every other encoding is reserved and causes no action. A reset input, or the test-logic-reset strobe, returns the block to its initial all-ones state, which selects bypass.

Top module: `dbg_ir_unit`

## Requirements
- R1: While `rst` is high, and at the first edge after it, `ir_view` is 0xFFFF, `sel_bypass` is 1, `sel_extest`, `sel_sample`, `dbg_rst` and `dbg_irq` are 0, and `tdo` is 1.
- R2: A `st_tlr` strobe gives the same state as R1 after its edge. It takes priority over an `st_update` in the same cycle.
- R3: During `st_shift`, each edge moves `tdi` into shift bit 15 and the other bits down by one. `tdo` shows shift bit 0, so a loaded word leaves LSB first. `ir_view` changes only on update or reset.
- R4: An `st_capture` edge loads the shift stage with 0xFFFD (bit 1 = 0, bit 0 = 1, other bits 1).
- R5: An `st_update` edge copies shift bits 15:8 into `ir_view[15:8]`. `ir_view[7:0]` stays 0xFF whatever was shifted into the lower byte.
- R6: After an update, `sel_extest` is 1 only for command 0x00, `sel_sample` only for 0x04, and `sel_bypass` only for 0xFF. At most one select is high at any time.
- R7: An update with command bits 7:4 equal to 0111 sets `dbg_rst` to 1, and 0110 clears it. Bits 3:0 are ignored. Every other command leaves `dbg_rst` unchanged.
- R8: An update with command bits 7:5 equal to 101 raises `dbg_irq` for exactly one cycle, whatever bits 4:0 are.
- R9: A reserved command (not 0x00, 0x04, 0xFF or one of the prefixes above) raises no select, no interrupt, and does not change `dbg_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high port reset |
| st_tlr | input | 1 | TAP is in test-logic-reset |
| st_capture | input | 1 | Capture strobe for the instruction path |
| st_shift | input | 1 | Shift strobe for the instruction path |
| st_update | input | 1 | Update strobe for the instruction path |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (shift bit 0) |
| ir_view | output | 16 | Read-only parallel instruction register |
| sel_extest | output | 1 | External test path selected |
| sel_sample | output | 1 | Sample/preload path selected |
| sel_bypass | output | 1 | Bypass path selected |
| dbg_rst | output | 1 | Sticky debug-reset level |
| dbg_irq | output | 1 | One-cycle debug interrupt request |

## Verification
Two functions can act in the same cycle. An update may coincide with a test-logic-reset strobe, and an update may coincide with a shift. The bench provokes the first case by raising `st_tlr` on the edge that would load a debug-reset-assert command. A correct design leaves bypass selected and `dbg_rst` low. The bench provokes the second case by keeping `st_shift` high through an update. The committed command must then be the one held before that edge, while the shift stage still advances. A behavioural model compares `tdo`, `ir_view` and every decode output on every clock.

// File: rtl/dbg_ir_pkg.sv
package dbg_ir_pkg;
  parameter int CMD_W = 8;

  typedef struct packed {
    logic extest;
    logic sample;
    logic bypass;
    logic rst_set;
    logic rst_clr;
    logic irq;
  } ir_dec_t;

  function automatic ir_dec_t decode_cmd(input logic [CMD_W-1:0] c);
    ir_dec_t d;
    d = '0;
    d.extest  = (c == 8'h00);
    d.sample  = (c == 8'h04);
    d.bypass  = (c == 8'hFF);
    d.rst_set = (c[7:4] == 4'b0111);
    d.rst_clr = (c[7:4] == 4'b0110);
    d.irq     = (c[7:5] == 3'b101);
    return d;
  endfunction
endpackage

// File: rtl/dbg_ir_shift.sv
module dbg_ir_shift #(
  parameter int IR_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            st_tlr,
  input  logic            st_capture,
  input  logic            st_shift,
  input  logic            tdi,
  output logic [IR_W-1:0] sr,
  output logic            tdo
);
  localparam logic [IR_W-1:0] CAPT = {{(IR_W-2){1'b1}}, 2'b01};

  always_ff @(posedge clk) begin
    if (rst || st_tlr)    sr <= '1;
    else if (st_capture)  sr <= CAPT;
    else if (st_shift)    sr <= {tdi, sr[IR_W-1:1]};
  end

  assign tdo = sr[0];

  // R3
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    (st_shift && !st_capture && !st_tlr) |=> sr[IR_W-1] == $past(tdi));
  // R4
  capture_pat_chk: assert property (@(posedge clk) disable iff (rst)
    (st_capture && !st_tlr) |=> (sr[1:0] == 2'b01 && tdo));
endmodule

// File: rtl/dbg_ir_hold.sv
module dbg_ir_hold #(
  parameter int IR_W  = 16,
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             st_tlr,
  input  logic             st_update,
  input  logic [CMD_W-1:0] cmd_in,
  output logic [IR_W-1:0]  hold
);
  localparam int LOW_W = IR_W - CMD_W;

  always_ff @(posedge clk) begin
    if (rst || st_tlr)   hold <= '1;
    else if (st_update)  hold <= {cmd_in, {LOW_W{1'b1}}};
  end

  // R5
  update_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (st_update && !st_tlr) |=> hold[IR_W-1 -: CMD_W] == $past(cmd_in));
  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!st_update && !st_tlr) |=> $stable(hold));
  // R2
  tlr_init_chk: assert property (@(posedge clk) disable iff (rst)
    st_tlr |=> hold == '1);
endmodule

// File: rtl/dbg_ir_decode.sv
module dbg_ir_decode
  import dbg_ir_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             st_tlr,
  input  logic             st_update,
  input  logic [CMD_W-1:0] cmd_in,
  output logic             sel_extest,
  output logic             sel_sample,
  output logic             sel_bypass,
  output logic             dbg_rst,
  output logic             dbg_irq
);
  ir_dec_t d;
  assign d = decode_cmd(cmd_in);

  always_ff @(posedge clk) begin
    if (rst || st_tlr) begin
      sel_extest <= 1'b0;
      sel_sample <= 1'b0;
      sel_bypass <= 1'b1;
      dbg_rst    <= 1'b0;
      dbg_irq    <= 1'b0;
    end else begin
      dbg_irq <= st_update && d.irq;
      if (st_update) begin
        sel_extest <= d.extest;
        sel_sample <= d.sample;
        sel_bypass <= d.bypass;
        if (d.rst_set)      dbg_rst <= 1'b1;
        else if (d.rst_clr) dbg_rst <= 1'b0;
      end
    end
  end

  // R6
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_extest, sel_sample, sel_bypass}));
  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_irq |=> !dbg_irq);
  // R7
  rst_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!st_update && !st_tlr) |=> $stable(dbg_rst));
  // R9
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st_update && !st_tlr && !d.extest && !d.sample && !d.bypass &&
     !d.rst_set && !d.rst_clr && !d.irq)
    |=> (!sel_extest && !sel_sample && !sel_bypass && !dbg_irq && $stable(dbg_rst)));
endmodule

// File: rtl/dbg_ir_unit.sv
module dbg_ir_unit
  import dbg_ir_pkg::*;
#(
  parameter int IR_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            st_tlr,
  input  logic            st_capture,
  input  logic            st_shift,
  input  logic            st_update,
  input  logic            tdi,
  output logic            tdo,
  output logic [IR_W-1:0] ir_view,
  output logic            sel_extest,
  output logic            sel_sample,
  output logic            sel_bypass,
  output logic            dbg_rst,
  output logic            dbg_irq
);
  logic [IR_W-1:0]  sr;
  logic [CMD_W-1:0] cmd;
  assign cmd = sr[IR_W-1 -: CMD_W];

  dbg_ir_shift #(.IR_W(IR_W)) u_shift (
    .clk(clk), .rst(rst), .st_tlr(st_tlr), .st_capture(st_capture),
    .st_shift(st_shift), .tdi(tdi), .sr(sr), .tdo(tdo)
  );

  dbg_ir_hold #(.IR_W(IR_W), .CMD_W(CMD_W)) u_hold (
    .clk(clk), .rst(rst), .st_tlr(st_tlr), .st_update(st_update),
    .cmd_in(cmd), .hold(ir_view)
  );

  dbg_ir_decode u_dec (
    .clk(clk), .rst(rst), .st_tlr(st_tlr), .st_update(st_update),
    .cmd_in(cmd), .sel_extest(sel_extest), .sel_sample(sel_sample),
    .sel_bypass(sel_bypass), .dbg_rst(dbg_rst), .dbg_irq(dbg_irq)
  );

  // R1
  reset_view_chk: assert property (@(posedge clk)
    rst |=> (ir_view == '1 && sel_bypass && !dbg_rst && !dbg_irq));
endmodule

// File: tb/dbg_ir_unit_bench.sv
module dbg_ir_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st_tlr = 1'b0, st_capture = 1'b0, st_shift = 1'b0, st_update = 1'b0;
  logic tdi = 1'b0;
  logic tdo, sel_extest, sel_sample, sel_bypass, dbg_rst, dbg_irq;
  logic [15:0] ir_view;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  dbg_ir_unit u_dbg_ir_unit (
    .clk(clk), .rst(rst), .st_tlr(st_tlr), .st_capture(st_capture),
    .st_shift(st_shift), .st_update(st_update), .tdi(tdi), .tdo(tdo),
    .ir_view(ir_view), .sel_extest(sel_extest), .sel_sample(sel_sample),
    .sel_bypass(sel_bypass), .dbg_rst(dbg_rst), .dbg_irq(dbg_irq)
  );

  // Behavioural model: queue front is shift bit 0
  bit q[$];
  int m_cmd = 255;
  bit m_ext, m_smp, m_byp = 1, m_drst, m_irq;

  function automatic void model_init();
    q = {};
    for (int i = 0; i < 16; i++) q.push_back(1'b1);
    m_cmd = 255; m_ext = 0; m_smp = 0; m_byp = 1; m_drst = 0; m_irq = 0;
  endfunction

  function automatic void model_step();
    int c;
    if (rst || st_tlr) begin
      model_init();
      return;
    end
    c = 0;
    for (int i = 8; i < 16; i++) c += int'(q[i]) << (i - 8);
    m_irq = st_update && ((c / 32) == 5);
    if (st_update) begin
      m_cmd = c;
      m_ext = (c == 0); m_smp = (c == 4); m_byp = (c == 255);
      if ((c / 16) == 7) m_drst = 1;
      else if ((c / 16) == 6) m_drst = 0;
    end
    if (st_capture) begin
      q = {};
      q.push_back(1'b1); q.push_back(1'b0);
      for (int i = 0; i < 14; i++) q.push_back(1'b1);
    end else if (st_shift) begin
      void'(q.pop_front());
      q.push_back(tdi);
    end
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R5 ir_view", ir_view, 16'((m_cmd << 8) | 8'hFF));
    chk("R3 tdo", {15'd0, tdo}, {15'd0, q[0]});
    chk("R6 sel_extest", {15'd0, sel_extest}, {15'd0, m_ext});
    chk("R6 sel_sample", {15'd0, sel_sample}, {15'd0, m_smp});
    chk("R6 sel_bypass", {15'd0, sel_bypass}, {15'd0, m_byp});
    chk("R7 dbg_rst", {15'd0, dbg_rst}, {15'd0, m_drst});
    chk("R8 dbg_irq", {15'd0, dbg_irq}, {15'd0, m_irq});
  endtask

  task automatic tick();
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic load(input logic [7:0] c, input logic [7:0] junk, input bit tlr_at_upd);
    logic [15:0] w;
    w = {c, junk};
    st_capture = 1; tick(); st_capture = 0;
    st_shift = 1;
    for (int i = 0; i < 16; i++) begin
      tdi = w[i];
      tick();
    end
    st_shift = 0; tdi = 0;
    st_update = 1; st_tlr = tlr_at_upd; tick();
    st_update = 0; st_tlr = 0;
    tick();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    model_init();
    @(negedge clk);
    tick(); tick();
    // R1 reset state
    chk("R1 ir_view", ir_view, 16'hFFFF);
    chk("R1 bypass", {15'd0, sel_bypass}, 16'd1);
    chk("R1 tdo", {15'd0, tdo}, 16'd1);
    rst = 0;
    tick();
    // R4 capture pattern, then first shift shows bit 1
    st_capture = 1; tick(); st_capture = 0;
    chk("R4 tdo bit0", {15'd0, tdo}, 16'd1);
    st_shift = 1; tdi = 1; tick(); st_shift = 0;
    chk("R4 tdo bit1", {15'd0, tdo}, 16'd0);
    chk("R3 view held", ir_view, 16'hFFFF);
    tick();
    load(8'h00, 8'h3C, 0);
    chk("R6 extest", {15'd0, sel_extest}, 16'd1);
    load(8'h04, 8'h00, 0);
    chk("R6 sample", {15'd0, sel_sample}, 16'd1);
    chk("R5 low byte", ir_view, 16'h04FF);
    load(8'h75, 8'hA5, 0);
    chk("R7 set", {15'd0, dbg_rst}, 16'd1);
    load(8'h9A, 8'h11, 0);
    chk("R9 reserved keeps rst", {15'd0, dbg_rst}, 16'd1);
    chk("R9 no select", {13'd0, sel_extest, sel_sample, sel_bypass}, 16'd0);
    load(8'hA3, 8'h00, 0);
    chk("R8 irq gone", {15'd0, dbg_irq}, 16'd0);
    load(8'h6F, 8'hFF, 0);
    chk("R7 clear", {15'd0, dbg_rst}, 16'd0);
    load(8'hBF, 8'h01, 0);
    load(8'h7E, 8'h00, 0);
    // R2 tlr beats update carrying a reset-assert command
    load(8'h70, 8'h00, 1);
    chk("R2 rst low", {15'd0, dbg_rst}, 16'd0);
    chk("R2 bypass", {15'd0, sel_bypass}, 16'd1);
    // update while shift continues
    load(8'h05, 8'h00, 0);
    st_shift = 1; st_update = 1; tdi = 0; tick();
    st_update = 0;
    for (int i = 0; i < 4; i++) begin tdi = 1; tick(); end
    st_shift = 0;
    chk("R9 05 reserved", ir_view, 16'h05FF);
    load(8'hFF, 8'h00, 0);
    chk("R6 bypass", {15'd0, sel_bypass}, 16'd1);
    load(8'h12, 8'h00, 0);
    rst = 1; tick(); rst = 0;
    chk("R1 rerun", ir_view, 16'hFFFF);
    tick();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule